// File: doc/BRIEF.md
# Burst-Splitting Memory-to-Memory Transfer Engine

This block performs one granted memory-to-memory copy at a time over a 32-bit AXI4 master. A request gives a source address, a destination address, a byte count and a flag that marks the final segment of a chain. The engine cuts the copy into INCR bursts. Each burst is first read completely into a 16-entry beat buffer. A write burst of the same length is then sent to the destination from that buffer.

The beat count of every burst is the smallest of three values: the words still to move, the global limit of 16 beats, and the cap of the requesting channel. Source and destination move forward together after each write burst that completes cleanly. A bad read or write response stops the copy and reports an error instead of completion. The chain-end flag comes back alongside either outcome.

Top module: `dma_burst_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `done_o`, `error_o`, `ar_valid_o`, `aw_valid_o`, `w_valid_o`, `r_ready_o` and `b_ready_o` are all low.
- R2: Each burst carries `min(words remaining, 16, cap)` beats, and its AR/AW length field holds that count minus one. The cap depends on `xfer_chan_i`: channel 0 uses 16, channel 1 uses 8 and channel 2 uses 4. Channel 3 uses `chan3_cap_i`, clamped so that 0 becomes 1 and anything above 16 becomes 16. The word count is the byte length divided by 4 and rounded up.
- R3: Every burst is marked as INCR (`2'b01`) with a 4-byte beat size (`3'b010`), and `w_strb_o` is all ones.
- R4: Within a burst, the read address phase and all read beats finish before the write address is presented. Write beats carry the read data in the order it was received.
- R5: The first burst uses the requested addresses. After each OKAY write response, both addresses advance by four times the beat count of that burst.
- R6: `w_last_o` is high on the final beat of each write burst and on no other beat.
- R7: When the last write response comes back OKAY, `done_o` goes high for exactly one cycle, the cycle after that response is accepted. `final_o` shows the request's chain-end flag in that cycle, and `busy_o` falls in the next cycle.
- R8: A read beat is faulty if its RRESP is not `2'b00`, or if its RLAST does not match its position in the burst. After a faulty beat the engine still accepts the rest of that burst. It then skips the write burst and starts no further bursts. `error_o` goes high for one cycle, the cycle after the final read beat.
- R9: A BRESP other than `2'b00` ends the copy. `error_o` goes high for one cycle, the cycle after the response, and no further burst follows.
- R10: A request is taken only while `busy_o` is low, and `busy_o` rises in the cycle after acceptance. A request presented while busy has no effect on the addresses, lengths or completion of the copy in progress.
- R11: A request whose byte length is zero raises `done_o` in the cycle after acceptance, with no bus activity.
- R12: Once `ar_valid_o`, `aw_valid_o` or `w_valid_o` is raised, it stays high with stable address, length and last-beat values until its handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_valid_i | input | 1 | Transfer request present |
| xfer_src_i | input | 32 | Source byte address |
| xfer_dst_i | input | 32 | Destination byte address |
| xfer_len_i | input | 24 | Byte count |
| xfer_last_i | input | 1 | Request is the last segment of its chain |
| xfer_chan_i | input | 2 | Requesting channel, which selects the burst cap |
| chan3_cap_i | input | 5 | Beat cap used by channel 3 |
| busy_o | output | 1 | Engine holds a request |
| done_o | output | 1 | One-cycle pulse for clean completion |
| error_o | output | 1 | One-cycle pulse for an aborted copy |
| final_o | output | 1 | Chain-end flag, valid during done or error |
| ar_addr_o | output | 32 | Read burst address |
| ar_len_o | output | 8 | Read beats minus one |
| ar_size_o | output | 3 | Read beat size |
| ar_burst_o | output | 2 | Read burst type |
| ar_valid_o | output | 1 | Read address valid |
| ar_ready_i | input | 1 | Read address ready |
| r_data_i | input | 32 | Read data |
| r_resp_i | input | 2 | Read response |
| r_last_i | input | 1 | Final read beat |
| r_valid_i | input | 1 | Read data valid |
| r_ready_o | output | 1 | Read data ready |
| aw_addr_o | output | 32 | Write burst address |
| aw_len_o | output | 8 | Write beats minus one |
| aw_size_o | output | 3 | Write beat size |
| aw_burst_o | output | 2 | Write burst type |
| aw_valid_o | output | 1 | Write address valid |
| aw_ready_i | input | 1 | Write address ready |
| w_data_o | output | 32 | Write data |
| w_strb_o | output | 4 | Write byte strobes |
| w_last_o | output | 1 | Final write beat |
| w_valid_o | output | 1 | Write data valid |
| w_ready_i | input | 1 | Write data ready |
| b_resp_i | input | 2 | Write response |
| b_valid_i | input | 1 | Write response valid |
| b_ready_o | output | 1 | Write response ready |

## Verification
Several properties are checked on every cycle: valid-hold stability on the three request channels, the burst length never reaching the active cap, at most one bus phase active at a time, done and error never high together, done lasting one cycle, and no address phase while idle. Other behaviour is shown only by the bench's scenarios, which sweep lengths across every channel and several channel-3 caps. These cover the arithmetic of burst splitting and address stepping, the forwarding of read data, the cycle in which completion appears, and the early stop after a read or write fault. The same applies to the rule that a request made while busy is ignored.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

    parameter int ADDR_W     = 32;
    parameter int DATA_W     = 32;
    parameter int LEN_W      = 24;
    parameter int MAX_BEATS  = 16;
    parameter int CHAN_W     = 2;

    localparam int STRB_W     = DATA_W / 8;
    localparam int BEAT_SHIFT = $clog2(STRB_W);
    localparam int WORDS_W    = LEN_W - BEAT_SHIFT + 1;
    localparam int BEAT_W     = $clog2(MAX_BEATS + 1);
    localparam int IDX_W      = $clog2(MAX_BEATS);

    localparam logic [2:0] SIZE_CODE = 3'(BEAT_SHIFT);
    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RADDR  = 3'd1,
        ST_RDATA  = 3'd2,
        ST_WADDR  = 3'd3,
        ST_WDATA  = 3'd4,
        ST_WRESP  = 3'd5,
        ST_FINISH = 3'd6
    } eng_state_e;

    typedef struct packed {
        eng_state_e          st;
        logic [ADDR_W-1:0]   src;
        logic [ADDR_W-1:0]   dst;
        logic [WORDS_W-1:0]  rem;
        logic [BEAT_W-1:0]   cap;
        logic [BEAT_W-1:0]   blen;
        logic [IDX_W-1:0]    idx;
        logic                last;
        logic                err;
    } eng_regs_t;

    function automatic logic [BEAT_W-1:0] chan_cap(input logic [CHAN_W-1:0] ch,
                                                   input logic [BEAT_W-1:0] cfg);
        logic [BEAT_W-1:0] c;
        case (ch)
            2'd0:    c = BEAT_W'(MAX_BEATS);
            2'd1:    c = BEAT_W'(MAX_BEATS / 2);
            2'd2:    c = BEAT_W'(MAX_BEATS / 4);
            default: begin
                if (cfg == '0)                    c = BEAT_W'(1);
                else if (cfg > BEAT_W'(MAX_BEATS)) c = BEAT_W'(MAX_BEATS);
                else                               c = cfg;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/xfer_burst_sizer.sv
module xfer_burst_sizer
    import dma_burst_pkg::*;
(
    input  logic [WORDS_W-1:0] rem_words_i,
    input  logic [BEAT_W-1:0]  cap_i,
    output logic [BEAT_W-1:0]  beats_o
);

    logic fits;

    always_comb begin
        fits    = rem_words_i < WORDS_W'(cap_i);
        beats_o = fits ? BEAT_W'(rem_words_i) : cap_i;
    end

endmodule

// File: rtl/xfer_beat_buffer.sv
module xfer_beat_buffer #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic                     clk_i,
    input  logic                     wr_en_i,
    input  logic [$clog2(DEPTH)-1:0] wr_idx_i,
    input  logic [WIDTH-1:0]         wr_data_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output logic [WIDTH-1:0]         rd_data_o
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
    import dma_burst_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_valid_i,
    input  logic [ADDR_W-1:0]   req_src_i,
    input  logic [ADDR_W-1:0]   req_dst_i,
    input  logic [LEN_W-1:0]    req_len_i,
    input  logic                req_last_i,
    input  logic [CHAN_W-1:0]   req_chan_i,
    input  logic [BEAT_W-1:0]   chan3_cap_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                error_o,
    output logic                final_o,
    output logic [WORDS_W-1:0]  rem_o,
    output logic [BEAT_W-1:0]   cap_o,
    input  logic [BEAT_W-1:0]   beats_i,
    output logic                buf_we_o,
    output logic [IDX_W-1:0]    buf_idx_o,
    output logic [ADDR_W-1:0]   ar_addr_o,
    output logic [7:0]          ar_len_o,
    output logic                ar_valid_o,
    input  logic                ar_ready_i,
    input  logic [1:0]          r_resp_i,
    input  logic                r_last_i,
    input  logic                r_valid_i,
    output logic                r_ready_o,
    output logic [ADDR_W-1:0]   aw_addr_o,
    output logic [7:0]          aw_len_o,
    output logic                aw_valid_o,
    input  logic                aw_ready_i,
    output logic                w_last_o,
    output logic                w_valid_o,
    input  logic                w_ready_i,
    input  logic [1:0]          b_resp_i,
    input  logic                b_valid_i,
    output logic                b_ready_o
);

    eng_regs_t q, d;

    logic                at_end;
    logic                beat_bad;
    logic [LEN_W:0]      len_round;
    logic [ADDR_W-1:0]   step;

    always_comb begin
        d          = q;
        buf_we_o   = 1'b0;
        ar_valid_o = 1'b0;
        r_ready_o  = 1'b0;
        aw_valid_o = 1'b0;
        w_valid_o  = 1'b0;
        b_ready_o  = 1'b0;
        done_o     = 1'b0;
        error_o    = 1'b0;
        at_end     = ({1'b0, q.idx} == (q.blen - BEAT_W'(1)));
        beat_bad   = 1'b0;
        len_round  = {1'b0, req_len_i} + (LEN_W+1)'(STRB_W - 1);
        step       = ADDR_W'(q.blen) << BEAT_SHIFT;

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.src  = req_src_i;
                    d.dst  = req_dst_i;
                    d.rem  = WORDS_W'(len_round >> BEAT_SHIFT);
                    d.cap  = chan_cap(req_chan_i, chan3_cap_i);
                    d.last = req_last_i;
                    d.err  = 1'b0;
                    d.idx  = '0;
                    d.st   = (d.rem == '0) ? ST_FINISH : ST_RADDR;
                end
            end
            ST_RADDR: begin
                ar_valid_o = 1'b1;
                if (ar_ready_i) begin
                    d.blen = beats_i;
                    d.idx  = '0;
                    d.st   = ST_RDATA;
                end
            end
            ST_RDATA: begin
                r_ready_o = 1'b1;
                if (r_valid_i) begin
                    buf_we_o = 1'b1;
                    beat_bad = (r_resp_i != RESP_OKAY) || (r_last_i != at_end);
                    d.err    = q.err | beat_bad;
                    d.idx    = q.idx + IDX_W'(1);
                    if (at_end) begin
                        d.idx = '0;
                        d.st  = d.err ? ST_FINISH : ST_WADDR;
                    end
                end
            end
            ST_WADDR: begin
                aw_valid_o = 1'b1;
                if (aw_ready_i) begin
                    d.idx = '0;
                    d.st  = ST_WDATA;
                end
            end
            ST_WDATA: begin
                w_valid_o = 1'b1;
                if (w_ready_i) begin
                    d.idx = q.idx + IDX_W'(1);
                    if (at_end) begin
                        d.idx = '0;
                        d.st  = ST_WRESP;
                    end
                end
            end
            ST_WRESP: begin
                b_ready_o = 1'b1;
                if (b_valid_i) begin
                    if (b_resp_i != RESP_OKAY) begin
                        d.err = 1'b1;
                        d.st  = ST_FINISH;
                    end else begin
                        d.src = q.src + step;
                        d.dst = q.dst + step;
                        d.rem = q.rem - WORDS_W'(q.blen);
                        d.st  = (q.rem == WORDS_W'(q.blen)) ? ST_FINISH : ST_RADDR;
                    end
                end
            end
            ST_FINISH: begin
                done_o  = ~q.err;
                error_o = q.err;
                d.st    = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.st != ST_IDLE);
    assign final_o   = (q.st == ST_FINISH) & q.last;
    assign rem_o     = q.rem;
    assign cap_o     = q.cap;
    assign buf_idx_o = q.idx;
    assign ar_addr_o = q.src;
    assign ar_len_o  = 8'(beats_i) - 8'd1;
    assign aw_addr_o = q.dst;
    assign aw_len_o  = 8'(q.blen) - 8'd1;
    assign w_last_o  = w_valid_o & at_end;

    AST_AR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ar_valid_o && !ar_ready_i |=> ar_valid_o && $stable(ar_addr_o) && $stable(ar_len_o)); // R12
    AST_AW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        aw_valid_o && !aw_ready_i |=> aw_valid_o && $stable(aw_addr_o) && $stable(aw_len_o)); // R12
    AST_W_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        w_valid_o && !w_ready_i |=> w_valid_o && $stable(w_last_o)); // R12
    AST_LEN_UNDER_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ar_valid_o |-> (9'(ar_len_o) < 9'(q.cap)) && (9'(ar_len_o) < 9'(MAX_BEATS))); // R2
    AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({ar_valid_o, r_ready_o, aw_valid_o, w_valid_o, b_ready_o})); // R4
    AST_WLAST_ENDS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        w_valid_o && w_last_o && w_ready_i |=> !w_valid_o); // R6
    AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && error_o)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o && !busy_o); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !ar_valid_o && !aw_valid_o && !w_valid_o); // R10

endmodule

// File: rtl/dma_burst_engine.sv
module dma_burst_engine
    import dma_burst_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                xfer_valid_i,
    input  logic [ADDR_W-1:0]   xfer_src_i,
    input  logic [ADDR_W-1:0]   xfer_dst_i,
    input  logic [LEN_W-1:0]    xfer_len_i,
    input  logic                xfer_last_i,
    input  logic [CHAN_W-1:0]   xfer_chan_i,
    input  logic [BEAT_W-1:0]   chan3_cap_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                error_o,
    output logic                final_o,
    output logic [ADDR_W-1:0]   ar_addr_o,
    output logic [7:0]          ar_len_o,
    output logic [2:0]          ar_size_o,
    output logic [1:0]          ar_burst_o,
    output logic                ar_valid_o,
    input  logic                ar_ready_i,
    input  logic [DATA_W-1:0]   r_data_i,
    input  logic [1:0]          r_resp_i,
    input  logic                r_last_i,
    input  logic                r_valid_i,
    output logic                r_ready_o,
    output logic [ADDR_W-1:0]   aw_addr_o,
    output logic [7:0]          aw_len_o,
    output logic [2:0]          aw_size_o,
    output logic [1:0]          aw_burst_o,
    output logic                aw_valid_o,
    input  logic                aw_ready_i,
    output logic [DATA_W-1:0]   w_data_o,
    output logic [STRB_W-1:0]   w_strb_o,
    output logic                w_last_o,
    output logic                w_valid_o,
    input  logic                w_ready_i,
    input  logic [1:0]          b_resp_i,
    input  logic                b_valid_i,
    output logic                b_ready_o
);

    logic [WORDS_W-1:0] rem_words;
    logic [BEAT_W-1:0]  cap;
    logic [BEAT_W-1:0]  beats;
    logic               buf_we;
    logic [IDX_W-1:0]   buf_idx;

    xfer_ctrl u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (xfer_valid_i),
        .req_src_i   (xfer_src_i),
        .req_dst_i   (xfer_dst_i),
        .req_len_i   (xfer_len_i),
        .req_last_i  (xfer_last_i),
        .req_chan_i  (xfer_chan_i),
        .chan3_cap_i (chan3_cap_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .error_o     (error_o),
        .final_o     (final_o),
        .rem_o       (rem_words),
        .cap_o       (cap),
        .beats_i     (beats),
        .buf_we_o    (buf_we),
        .buf_idx_o   (buf_idx),
        .ar_addr_o   (ar_addr_o),
        .ar_len_o    (ar_len_o),
        .ar_valid_o  (ar_valid_o),
        .ar_ready_i  (ar_ready_i),
        .r_resp_i    (r_resp_i),
        .r_last_i    (r_last_i),
        .r_valid_i   (r_valid_i),
        .r_ready_o   (r_ready_o),
        .aw_addr_o   (aw_addr_o),
        .aw_len_o    (aw_len_o),
        .aw_valid_o  (aw_valid_o),
        .aw_ready_i  (aw_ready_i),
        .w_last_o    (w_last_o),
        .w_valid_o   (w_valid_o),
        .w_ready_i   (w_ready_i),
        .b_resp_i    (b_resp_i),
        .b_valid_i   (b_valid_i),
        .b_ready_o   (b_ready_o)
    );

    xfer_burst_sizer u_sizer (
        .rem_words_i (rem_words),
        .cap_i       (cap),
        .beats_o     (beats)
    );

    xfer_beat_buffer #(
        .DEPTH (MAX_BEATS),
        .WIDTH (DATA_W)
    ) u_buf (
        .clk_i     (clk_i),
        .wr_en_i   (buf_we),
        .wr_idx_i  (buf_idx),
        .wr_data_i (r_data_i),
        .rd_idx_i  (buf_idx),
        .rd_data_o (w_data_o)
    );

    assign ar_size_o  = SIZE_CODE;
    assign aw_size_o  = SIZE_CODE;
    assign ar_burst_o = BURST_INCR;
    assign aw_burst_o = BURST_INCR;
    assign w_strb_o   = '1;

endmodule

// File: tb/dma_burst_engine_bench.sv
module dma_burst_engine_bench;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        xfer_valid_i = 1'b0;
    logic [31:0] xfer_src_i = '0, xfer_dst_i = '0;
    logic [23:0] xfer_len_i = '0;
    logic        xfer_last_i = 1'b0;
    logic [1:0]  xfer_chan_i = '0;
    logic [4:0]  chan3_cap_i = '0;
    logic        busy_o, done_o, error_o, final_o;
    logic [31:0] ar_addr_o, aw_addr_o, w_data_o;
    logic [7:0]  ar_len_o, aw_len_o;
    logic [2:0]  ar_size_o, aw_size_o;
    logic [1:0]  ar_burst_o, aw_burst_o;
    logic        ar_valid_o, aw_valid_o, w_valid_o, w_last_o, r_ready_o, b_ready_o;
    logic [3:0]  w_strb_o;
    logic        ar_ready_i = 1'b0, aw_ready_i = 1'b0, w_ready_i = 1'b0;
    logic [31:0] r_data_i = '0;
    logic [1:0]  r_resp_i = '0, b_resp_i = '0;
    logic        r_last_i = 1'b0, r_valid_i = 1'b0, b_valid_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk_i = ~clk_i;

    dma_burst_engine u_dma_burst_engine (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    function automatic int cap_for(input logic [1:0] ch, input logic [4:0] c3);
        case (ch)
            2'd0: return 16;
            2'd1: return 8;
            2'd2: return 4;
            default: return (c3 == 0) ? 1 : ((c3 > 16) ? 16 : int'(c3));
        endcase
    endfunction

    task automatic run_xfer(input logic [31:0] src, input logic [31:0] dst, input int len,
                            input logic [1:0] ch, input logic [4:0] c3, input logic lst,
                            input int rerr_burst, input int rerr_beat, input int berr_burst,
                            input int stall, input bit poke);
        int rem, cap, n, b, t;
        logic [31:0] s, d;
        @(negedge clk_i);
        xfer_valid_i = 1'b1; xfer_src_i = src; xfer_dst_i = dst; xfer_len_i = 24'(len);
        xfer_chan_i = ch; chan3_cap_i = c3; xfer_last_i = lst;
        @(negedge clk_i);
        xfer_valid_i = 1'b0;
        check(busy_o == 1'b1, "R10 busy after accept", {31'b0, busy_o}, 32'd1);
        rem = (len + 3) / 4; cap = cap_for(ch, c3); s = src; d = dst; b = 0;
        if (rem == 0) begin
            check(done_o && !error_o && !ar_valid_o, "R11 zero length done", {29'b0, done_o, error_o, ar_valid_o}, 32'b100);
            check(final_o == lst, "R7 final flag", {31'b0, final_o}, {31'b0, lst});
            @(negedge clk_i);
            check(!busy_o && !done_o, "R11 idle after", {30'b0, busy_o, done_o}, 32'd0);
            return;
        end
        while (rem > 0) begin
            n = (rem < cap) ? rem : cap;
            t = 0;
            while (!ar_valid_o && t < 50) begin @(negedge clk_i); t++; end
            if (poke && b == 0) begin
                xfer_valid_i = 1'b1; xfer_src_i = 32'hDEAD_0000; xfer_dst_i = 32'hBEEF_0000;
                xfer_len_i = 24'h40; xfer_chan_i = 2'd0;
                @(negedge clk_i);
                xfer_valid_i = 1'b0;
            end
            repeat (stall) @(negedge clk_i);
            check(ar_valid_o, "R12 ar held", {31'b0, ar_valid_o}, 32'd1);
            check(ar_addr_o == s, "R5 read address", ar_addr_o, s);
            check(ar_len_o == 8'(n - 1), "R2 read length", {24'b0, ar_len_o}, 32'(n - 1));
            check(ar_size_o == 3'b010 && ar_burst_o == 2'b01, "R3 read attrs", {27'b0, ar_size_o, ar_burst_o}, 32'b01001);
            ar_ready_i = 1'b1;
            @(negedge clk_i);
            ar_ready_i = 1'b0;
            for (int k = 0; k < n; k++) begin
                check(r_ready_o && !aw_valid_o, "R4 read before write", {30'b0, r_ready_o, aw_valid_o}, 32'b10);
                r_valid_i = 1'b1; r_data_i = pat(s + 32'(4 * k)); r_last_i = (k == n - 1);
                r_resp_i = (b == rerr_burst && k == rerr_beat) ? 2'b10 : 2'b00;
                @(negedge clk_i);
            end
            r_valid_i = 1'b0; r_last_i = 1'b0; r_resp_i = 2'b00;
            if (b == rerr_burst) begin
                check(error_o && !done_o && !aw_valid_o, "R8 read error", {29'b0, error_o, done_o, aw_valid_o}, 32'b100);
                check(final_o == lst, "R8 final flag", {31'b0, final_o}, {31'b0, lst});
                @(negedge clk_i);
                check(!busy_o && !ar_valid_o && !error_o, "R8 stopped", {29'b0, busy_o, ar_valid_o, error_o}, 32'd0);
                return;
            end
            check(aw_valid_o, "R4 write address after reads", {31'b0, aw_valid_o}, 32'd1);
            check(aw_addr_o == d, "R5 write address", aw_addr_o, d);
            check(aw_len_o == 8'(n - 1), "R2 write length", {24'b0, aw_len_o}, 32'(n - 1));
            check(aw_size_o == 3'b010 && aw_burst_o == 2'b01, "R3 write attrs", {27'b0, aw_size_o, aw_burst_o}, 32'b01001);
            aw_ready_i = 1'b1;
            @(negedge clk_i);
            aw_ready_i = 1'b0; w_ready_i = 1'b1;
            for (int k = 0; k < n; k++) begin
                check(w_valid_o && w_data_o == pat(s + 32'(4 * k)), "R4 write data", w_data_o, pat(s + 32'(4 * k)));
                check(w_last_o == (k == n - 1), "R6 wlast", {31'b0, w_last_o}, {31'b0, (k == n - 1)});
                if (k == 0) check(w_strb_o == 4'hF, "R3 strobes", {28'b0, w_strb_o}, 32'hF);
                @(negedge clk_i);
            end
            w_ready_i = 1'b0;
            check(b_ready_o && !w_valid_o, "R6 burst closed", {30'b0, b_ready_o, w_valid_o}, 32'b10);
            b_valid_i = 1'b1; b_resp_i = (b == berr_burst) ? 2'b10 : 2'b00;
            @(negedge clk_i);
            b_valid_i = 1'b0; b_resp_i = 2'b00;
            if (b == berr_burst) begin
                check(error_o && !done_o, "R9 write error", {30'b0, error_o, done_o}, 32'b10);
                @(negedge clk_i);
                check(!busy_o && !ar_valid_o, "R9 stopped", {30'b0, busy_o, ar_valid_o}, 32'd0);
                return;
            end
            rem -= n; s += 32'(4 * n); d += 32'(4 * n); b++;
        end
        check(done_o && !error_o, "R7 done pulse", {30'b0, done_o, error_o}, 32'b10);
        check(final_o == lst, "R7 final flag", {31'b0, final_o}, {31'b0, lst});
        @(negedge clk_i);
        check(!done_o && !busy_o, "R7 pulse ends", {30'b0, done_o, busy_o}, 32'd0);
    endtask

    initial begin
        #1_500_000;
        check(1'b0, "WATCHDOG", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check(!busy_o && !done_o && !error_o && !ar_valid_o && !aw_valid_o && !w_valid_o
              && !r_ready_o && !b_ready_o, "R1 reset state", {31'b0, busy_o}, 32'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check(!busy_o && !ar_valid_o, "R1 idle after reset", {30'b0, busy_o, ar_valid_o}, 32'd0);
        for (int ch = 0; ch < 3; ch++) begin
            for (int w = 0; w < 35; w++) begin
                run_xfer(32'h1000_0000 + 32'(w * 512), 32'h2000_0000 + 32'(w * 1024),
                         w * 4 - ((w > 0) ? (w % 4) : 0), 2'(ch), 5'd0, 1'(w % 2),
                         -1, -1, -1, w % 3, 1'b0);
            end
        end
        for (int ci = 0; ci < 5; ci++) begin
            for (int wi = 0; wi < 6; wi++) begin
                logic [4:0] c3;
                int w;
                c3 = (ci == 0) ? 5'd0 : (ci == 1) ? 5'd1 : (ci == 2) ? 5'd5 : (ci == 3) ? 5'd16 : 5'd25;
                w  = (wi == 0) ? 0 : (wi == 1) ? 1 : (wi == 2) ? 3 : (wi == 3) ? 9 : (wi == 4) ? 17 : 33;
                run_xfer(32'h3000_0100 + 32'(ci * 4096), 32'h4000_0040, w * 4, 2'd3, c3, 1'b1,
                         -1, -1, -1, 0, 1'b0);
            end
        end
        run_xfer(32'h5000_0000, 32'h6000_0000, 80, 2'd2, 5'd0, 1'b1, 1, 2, -1, 0, 1'b0);
        run_xfer(32'h5000_1000, 32'h6000_1000, 64, 2'd0, 5'd0, 1'b0, 0, 15, -1, 1, 1'b0);
        run_xfer(32'h5000_2000, 32'h6000_2000, 96, 2'd1, 5'd0, 1'b1, -1, -1, 2, 0, 1'b0);
        run_xfer(32'h5000_3000, 32'h6000_3000, 40, 2'd2, 5'd0, 1'b1, -1, -1, 0, 0, 1'b0);
        run_xfer(32'h7000_0000, 32'h7800_0000, 48, 2'd1, 5'd0, 1'b1, -1, -1, -1, 2, 1'b1);
        @(negedge clk_i);
        check(!busy_o, "R10 busy request ignored", {31'b0, busy_o}, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule